// File: doc/BRIEF.md
# DMA Channel Priority Arbiter

This block decides which pending DMA channel owns the shared bus for its next element transfer. Every channel drives a request line and a two-bit software level. The arbiter ranks the requesters in two stages. The first stage finds the highest software level among the pending channels. The second stage picks the lowest-numbered channel at that level. The winner receives a one-hot grant. The grant stays in place until the bus side reports that the element has finished.

A second controller may also be attached through a single request line. It gets the bus only when no local channel is pending, and it is told so through its own grant output. Both kinds of grant end on the same completion pulse.

The control is a three-state machine:
- **ST_IDLE**: no grant is held.
- **ST_LOCAL**: a local channel holds the bus.
- **ST_EXT**: the second controller holds the bus.

A decision is taken in ST_IDLE on every cycle, and in the two holding states only in a cycle where `xfer_done` is high. That decision takes one of three transitions:
- **to ST_LOCAL** if any local request is pending;
- **to ST_EXT** if only the external request is pending;
- **to ST_IDLE** if nothing is pending.

In a holding state without `xfer_done`, the transition is **hold**: the state and the grant stay unchanged.

Top module: `dma_prio_arbiter`

## Requirements
- R1: A channel's level is the two-bit field `ch_level[2i+1:2i]`, coded 11 very high, 10 high, 01 medium, 00 low. A pending channel at a higher level always wins over one at a lower level.
- R2: Among pending channels that share the highest pending level, the lowest channel index is granted.
- R3: At most one bit is high across `ch_grant` and `ext_grant` together.
- R4: Once given, a grant stays unchanged until a cycle with `xfer_done` high. This holds even if the granted request drops or a higher-level request arrives.
- R5: If no request is pending at a decision point, both grant outputs are zero from the next cycle on.
- R6: A channel whose request is low in the decision cycle is not granted, whatever its level.
- R7: `ext_grant` is given only when no local request is pending at the decision point. Any pending local channel takes precedence.
- R8: A decision point lies in ST_IDLE, or in a holding cycle with `xfer_done` high. The new grant appears on the clock edge that ends that cycle, with no idle cycle in between.
- R9: While `rst_n` is low, and directly after it rises, both grant outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_req | input | NUM_CH | Per-channel request |
| ch_level | input | 2*NUM_CH | Per-channel software level, two bits per channel |
| ext_req | input | 1 | Request from the second controller |
| xfer_done | input | 1 | Current element transfer has completed |
| ch_grant | output | NUM_CH | One-hot local grant |
| ext_grant | output | 1 | Grant to the second controller |

## Verification
Two events can fall in the same cycle: the completion of the current element and a change in the pending request set. Examples of such a change are a new high-level request, a dropped request, or the granted channel re-requesting.

The bench provokes this collision directly with directed cases, for instance a very-high request that drops in exactly the done cycle. It also provokes it many times through random stimulus in which `xfer_done` fires in about a third of cycles.

A bench model is updated at each edge from the inputs that were presented. From that model it decides whether the cycle was a decision point and which channel should then win. The outputs are compared with this model after every edge.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

    localparam int LVL_W   = 2;
    localparam int NUM_LVL = 1 << LVL_W;

    typedef enum logic [LVL_W-1:0] {
        LVL_LOW   = 2'b00,
        LVL_MED   = 2'b01,
        LVL_HIGH  = 2'b10,
        LVL_VHIGH = 2'b11
    } lvl_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOCAL = 2'd1,
        ST_EXT   = 2'd2
    } arb_st_e;

endpackage

// File: rtl/dma_arb_level_scan.sv
module dma_arb_level_scan
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic [NUM_CH-1:0]       req,
    input  logic [LVL_W*NUM_CH-1:0] lvl,
    output logic [NUM_CH-1:0]       cand,
    output logic                    any
);

    logic [NUM_LVL*NUM_CH-1:0] at_flat;

    // stage one: group the pending channels by software level
    for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            assign at_flat[l*NUM_CH + c] =
                req[c] && (lvl[c*LVL_W +: LVL_W] == LVL_W'(l));
        end
    end

    assign any = |req;

    always_comb begin
        logic found;
        found = 1'b0;
        cand  = '0;
        for (int l = NUM_LVL-1; l >= 0; l--) begin
            if (!found && (|at_flat[l*NUM_CH +: NUM_CH])) begin
                cand  = at_flat[l*NUM_CH +: NUM_CH];
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_arb_pick_first.sv
module dma_arb_pick_first #(
    parameter int NUM_CH = 7
) (
    input  logic [NUM_CH-1:0] cand,
    output logic [NUM_CH-1:0] onehot
);

    // stage two: lowest index among equal-level candidates
    always_comb begin
        logic taken;
        taken  = 1'b0;
        onehot = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (cand[i] && !taken) begin
                onehot[i] = 1'b1;
                taken     = 1'b1;
            end
        end
    end

endmodule

// File: rtl/dma_prio_arbiter.sv
module dma_prio_arbiter
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NUM_CH-1:0]       ch_req,
    input  logic [LVL_W*NUM_CH-1:0] ch_level,
    input  logic                    ext_req,
    input  logic                    xfer_done,
    output logic [NUM_CH-1:0]       ch_grant,
    output logic                    ext_grant
);

    arb_st_e           st_q, st_d;
    logic [NUM_CH-1:0] grant_q, grant_d;
    logic [NUM_CH-1:0] cand, winner;
    logic              any_local;
    logic              decide;
    arb_st_e           pick_st;

    dma_arb_level_scan #(.NUM_CH(NUM_CH)) u_scan (
        .req  (ch_req),
        .lvl  (ch_level),
        .cand (cand),
        .any  (any_local)
    );

    dma_arb_pick_first #(.NUM_CH(NUM_CH)) u_pick (
        .cand   (cand),
        .onehot (winner)
    );

    assign pick_st = any_local ? ST_LOCAL : (ext_req ? ST_EXT : ST_IDLE);

    // next state
    always_comb begin
        st_d   = st_q;
        decide = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                decide = 1'b1;
                st_d   = pick_st;
            end
            ST_LOCAL, ST_EXT: begin
                if (xfer_done) begin
                    decide = 1'b1;
                    st_d   = pick_st;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        grant_d = grant_q;
        if (decide) begin
            grant_d = any_local ? winner : '0;
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            grant_q <= '0;
        end else begin
            grant_q <= grant_d;
        end
    end

    assign ch_grant  = grant_q;
    assign ext_grant = (st_q == ST_EXT);

endmodule

// File: rtl/dma_prio_arbiter_chk.sv
module dma_prio_arbiter_chk
    import dma_arb_pkg::*;
#(
    parameter int NUM_CH = 7
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [NUM_CH-1:0]       ch_req,
    input logic [LVL_W*NUM_CH-1:0] ch_level,
    input logic                    ext_req,
    input logic                    xfer_done,
    input logic [NUM_CH-1:0]       ch_grant,
    input logic                    ext_grant
);

    logic                    open_w;
    logic [LVL_W-1:0]        max_pend;
    logic [LVL_W-1:0]        win_lvl;
    logic [LVL_W*NUM_CH-1:0] lvl_q;

    assign open_w = ((ch_grant == '0) && !ext_grant) || xfer_done;

    always_comb begin
        max_pend = '0;
        win_lvl  = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_req[i] && ch_level[i*LVL_W +: LVL_W] > max_pend) begin
                max_pend = ch_level[i*LVL_W +: LVL_W];
            end
            if (ch_grant[i]) begin
                win_lvl = lvl_q[i*LVL_W +: LVL_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        lvl_q <= ch_level;
    end

    // R3
    one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ext_grant, ch_grant}));

    // R4
    hold_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_done && (ch_grant != '0 || ext_grant))
        |=> (ch_grant == $past(ch_grant)) && (ext_grant == $past(ext_grant)));

    // R5
    none_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_w && ch_req == '0 && !ext_req) |=> (ch_grant == '0) && !ext_grant);

    // R6
    req_targeted_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_w && ch_req != '0) |=> ((ch_grant & $past(ch_req)) != '0));

    // R7
    local_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_w && ch_req != '0) |=> !ext_grant);

    // R1
    top_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_w && ch_req != '0) |=> (win_lvl == $past(max_pend)));

    // R8
    ext_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open_w && ch_req == '0 && ext_req) |=> ext_grant);

endmodule

bind dma_prio_arbiter dma_prio_arbiter_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ch_req    (ch_req),
    .ch_level  (ch_level),
    .ext_req   (ext_req),
    .xfer_done (xfer_done),
    .ch_grant  (ch_grant),
    .ext_grant (ext_grant)
);

// File: tb/dma_prio_arbiter_bench.sv
`timescale 1ns/1ps
module dma_prio_arbiter_bench;

    localparam int N = 7;

    logic         clk = 1'b0;
    logic         rst_n;
    logic [N-1:0] ch_req;
    logic [2*N-1:0] ch_level;
    logic         ext_req;
    logic         xfer_done;
    logic [N-1:0] ch_grant;
    logic         ext_grant;

    int checks   = 0;
    int failures = 0;
    logic [N-1:0] exp_g;
    logic         exp_e;
    bit           finished = 1'b0;

    always #4 clk = ~clk;

    dma_prio_arbiter #(.NUM_CH(N)) u_dma_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .ch_req(ch_req), .ch_level(ch_level),
        .ext_req(ext_req), .xfer_done(xfer_done),
        .ch_grant(ch_grant), .ext_grant(ext_grant)
    );

    function automatic logic [N-1:0] model_pick(input logic [N-1:0] r,
                                                input logic [2*N-1:0] lv);
        logic [N-1:0] res;
        int best;
        res  = '0;
        best = -1;
        for (int i = 0; i < N; i++) begin
            if (r[i] && int'(lv[2*i +: 2]) > best) begin
                best = int'(lv[2*i +: 2]);
                res  = '0;
                res[i] = 1'b1;
            end
        end
        return res;
    endfunction

    function automatic logic [2*N-1:0] lvset(input logic [2*N-1:0] v,
                                             input int ch, input logic [1:0] l);
        logic [2*N-1:0] o;
        o = v;
        o[2*ch +: 2] = l;
        return o;
    endfunction

    task automatic compare(input string tag);
        checks++;
        if (ch_grant !== exp_g || ext_grant !== exp_e) begin
            failures++;
            $display("FAIL %s: grant=%b ext=%b expected grant=%b ext=%b",
                     tag, ch_grant, ext_grant, exp_g, exp_e);
        end
    endtask

    task automatic cycle(input logic [N-1:0] r, input logic [2*N-1:0] lv,
                         input logic e, input logic d, input string tag);
        bit open;
        ch_req = r; ch_level = lv; ext_req = e; xfer_done = d;
        open = ((exp_g == '0) && !exp_e) || d;
        if (open) begin
            if (r != '0) begin
                exp_g = model_pick(r, lv); exp_e = 1'b0;
            end else begin
                exp_g = '0; exp_e = e;
            end
        end
        @(posedge clk); #1;
        compare(tag);
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [2*N-1:0] lv;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; ch_req = '0; ch_level = '0; ext_req = 1'b0; xfer_done = 1'b0;
        exp_g = '0; exp_e = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        ch_req = 7'h7f; ext_req = 1'b1;
        @(posedge clk); #1;
        compare("R9 grant during reset");
        ch_req = '0; ext_req = 1'b0;
        rst_n = 1'b1;
        compare("R9 grant after reset");

        cycle('0, '0, 1'b0, 1'b0, "R5 idle no request");
        // R1: channel 5 very high beats channel 3 low
        lv = lvset('0, 5, 2'b11);
        cycle(7'b0101000, lv, 1'b0, 1'b0, "R1 higher level wins");
        // R4: no preemption by a very high newcomer, granted req dropped
        lv = lvset(lv, 0, 2'b11);
        cycle(7'b0001001, lv, 1'b0, 1'b0, "R4 grant held");
        // R2 with R8: done, channels 2 and 4 both high
        lv = lvset(lvset('0, 2, 2'b10), 4, 2'b10);
        cycle(7'b0010100, lv, 1'b0, 1'b1, "R2 R8 tie lowest index");
        // R6: channel 1 very high drops in done cycle, channel 6 medium pending
        lv = lvset(lvset('0, 1, 2'b11), 6, 2'b01);
        cycle(7'b1000000, lv, 1'b0, 1'b1, "R6 dropped request ignored");
        // R7: local pending blocks external
        cycle(7'b0000100, '0, 1'b1, 1'b1, "R7 local over external");
        cycle('0, '0, 1'b1, 1'b1, "R7 external when alone");
        cycle(7'b0000001, '0, 1'b0, 1'b0, "R4 external held");
        cycle('0, '0, 1'b0, 1'b1, "R5 done nothing pending");
        cycle('0, '0, 1'b0, 1'b0, "R5 stays idle");
        // R1: medium at 0, high at 6
        lv = lvset(lvset('0, 0, 2'b01), 6, 2'b10);
        cycle(7'b1000001, lv, 1'b0, 1'b0, "R1 level over index");

        for (int k = 0; k < 400; k++) begin
            logic [N-1:0]   r;
            logic [2*N-1:0] l;
            r = N'($urandom) & N'($urandom);
            l = (2*N)'($urandom);
            cycle(r, l, 1'($urandom), ($urandom % 3) == 0, "R1 R2 R3 R4 R6 R7 random");
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule